// File: doc/BRIEF.md
# Oversampled One-Bit Converter Controller

This block is the digital half of a first-order sigma-delta analog-to-digital converter. Outside the chip sit an RC integrator and a comparator (or just a logic input threshold). On every rising edge of the oversampling clock, the block takes in the comparator decision. It passes that decision through a short synchronizer and registers it as the current stream bit. The same registered bit is driven back out as the one-bit DAC level that feeds the integrator. A high feedback level stands for the positive reference and a low level for the negative reference. This closes the modulator loop.

The fraction of ones in the stream tracks the input voltage. The block turns that fraction into numbers with a boxcar decimator. It counts the ones over back-to-back windows of 2^M stream bits and presents each count as an M-bit result with a one-cycle valid strobe. A window made up entirely of ones would count 2^M, which does not fit in M bits, so that count is clipped to the all-ones code. Each window starts on the edge right after the previous one closes, so every stream bit lands in exactly one window. The clock is expected to run many times faster than the Nyquist rate of the measured signal.

Top module: `sd_adc_ctrl`

## Requirements
- R1: While `rst_n` is low, `fb_out`, `result_valid` and `result` are all 0.
- R2: `fb_out` is the stream bit. After the third rising edge following reset release, `fb_out` equals the value `cmp_in` had at the rising edge three edges earlier (two synchronizer flops, then the stream register). `fb_out` changes only at rising edges.
- R3: `result_valid` is high for exactly one cycle after every 2^M-th rising edge counted from reset release (M = `RES_BITS`, default 8). It is low in every other cycle.
- R4: `result` is the number of ones among the 2^M `fb_out` values consumed by the edges of the window that just closed. `fb_out` is consumed as it stood just before each edge.
- R5: A window of only zeros gives `result` = 0. A window of only ones gives `result` = 2^M-1, the all-ones code, instead of wrapping.
- R6: Consecutive windows split the stream with no gap and no overlap. The window that closes on edge k*2^M covers edges (k-1)*2^M+1 through k*2^M. For example, a stream with a one on every fourth bit of a window gives exactly 2^M/4, and a stream whose bit index modulo 8 is below 3 gives exactly 3*2^M/8.
- R7: `result` keeps its value in every cycle in which `result_valid` is low.
- R8: When the loop is closed around an integrator that adds (vin - fb*FULL) each clock and a comparator that reports integrator > 0, each window's `result` lies within 12 codes of vin*2^M/FULL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock; every rising edge consumes one stream bit |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_in | input | 1 | Comparator decision from the external integrator, asynchronous to `clk` |
| fb_out | output | 1 | Registered stream bit, driven to the one-bit DAC (1 = +reference, 0 = -reference) |
| result | output | RES_BITS | Count of ones in the last completed window, clipped to all ones |
| result_valid | output | 1 | One-cycle strobe marking a new `result` |

## Verification
The bench targets three places where this block can go wrong.

Window edges: a counter that restarts one cycle late, or drops the bit that arrives on the closing edge, shifts the phase-locked patterns. Those patterns then miss their exact counts of a quarter and three eighths of the window. The cycle-exact strobe check also catches such a counter, because its strobe arrives early or late.

Saturation: an all-ones window is run twice, because a design that forgets to clip shows 0 there instead of all ones.

Loop latency: every stream bit is compared against the comparator value from three edges earlier, so an extra or missing flop shows up at once. Closed-loop windows at three input levels then confirm that the ones density follows the input.

// File: rtl/sd_adc_pkg.sv
package sd_adc_pkg;

  // Upper bound accepted for the result width.
  localparam int unsigned SD_MAX_RES_BITS = 24;

  // Length of one decimation window for a given result width.
  function automatic logic [31:0] sd_window_len(input int unsigned res_bits);
    return 32'd1 << res_bits;
  endfunction

  // Clip a raw ones count to the largest code a res_bits-wide result can hold.
  function automatic logic [31:0] sd_clip_count(input logic [31:0] ones,
                                                input int unsigned res_bits);
    logic [31:0] top_code;
    top_code = sd_window_len(res_bits) - 32'd1;
    return (ones > top_code) ? top_code : ones;
  endfunction

endpackage

// File: rtl/sd_sync.sv
module sd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/sd_fb_reg.sv
module sd_fb_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic decision,
  output logic stream_bit
);

  // Registered stream bit; it also drives the one-bit DAC, so it may only
  // move on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stream_bit <= 1'b0;
    else        stream_bit <= decision;
  end

endmodule

// File: rtl/sd_boxcar.sv
module sd_boxcar
  import sd_adc_pkg::*;
#(
  parameter int RES_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_bit,
  output logic [RES_BITS-1:0] result,
  output logic                result_valid
);

  localparam int ACC_W = RES_BITS + 1;

  logic [RES_BITS-1:0] idx;
  logic [ACC_W-1:0]    acc;
  logic [ACC_W-1:0]    total;
  logic [31:0]         clipped;
  logic                window_end;

  // Named events for the checks below.
  assign window_end = (idx == {RES_BITS{1'b1}});
  assign total      = acc + ACC_W'(sample_bit);

  always_comb begin
    clipped = sd_clip_count(32'(total), RES_BITS);
  end

  // Sample index and running count. The last sample of a window is folded
  // into the result, and the next window restarts on the following edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      acc <= '0;
    end else begin
      idx <= idx + 1'b1;
      acc <= window_end ? '0 : total;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= window_end;
      if (window_end) result <= clipped[RES_BITS-1:0];
    end
  end

  // R4: the count never runs ahead of the samples taken.
  p_acc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= {1'b0, idx});

  // R3: the strobe never lasts two cycles.
  p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R6: a closing window is followed by a strobe and a fresh index.
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    window_end |=> (result_valid && idx == '0));

  // R7: the result holds between strobes.
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result));

  // R5: a full window of ones lands on the all-ones code.
  p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (window_end && sample_bit && acc == {1'b0, {RES_BITS{1'b1}}})
      |=> result == {RES_BITS{1'b1}});

endmodule

// File: rtl/sd_adc_ctrl.sv
module sd_adc_ctrl
  import sd_adc_pkg::*;
#(
  parameter int RES_BITS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_in,
  output logic                fb_out,
  output logic [RES_BITS-1:0] result,
  output logic                result_valid
);

  localparam int LAT    = SYNC_STAGES + 1;
  localparam int WARM_W = $clog2(LAT + 1);

  logic cmp_sync;

  sd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cmp_in),
    .sync_out (cmp_sync)
  );

  sd_fb_reg u_fb (
    .clk        (clk),
    .rst_n      (rst_n),
    .decision   (cmp_sync),
    .stream_bit (fb_out)
  );

  sd_boxcar #(.RES_BITS(RES_BITS)) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_bit   (fb_out),
    .result       (result),
    .result_valid (result_valid)
  );

  // Edges since reset, saturating, so the latency check never looks
  // back past reset.
  logic [WARM_W-1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 warm <= '0;
    else if (warm != WARM_W'(LAT)) warm <= warm + 1'b1;
  end

  // R2: the loop bit is the comparator value from LAT edges before.
  p_fb_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == WARM_W'(LAT)) |-> (fb_out == $past(cmp_in, LAT)));

endmodule

// File: tb/sim_sd_adc_ctrl.sv
`timescale 1ns/100ps
module sim_sd_adc_ctrl;

  localparam int M    = 8;
  localparam int W    = 1 << M;
  localparam int FULL = 1024;
  localparam int NWIN = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmp_in = 1'b0;
  logic         fb_out;
  logic [M-1:0] result;
  logic         result_valid;

  int total_checks = 0;
  int bad_checks   = 0;
  bit finished     = 0;

  always #2.5 clk = ~clk;

  sd_adc_ctrl #(.RES_BITS(M), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in),
    .fb_out(fb_out), .result(result), .result_valid(result_valid)
  );

  typedef struct { int win; int val; } exp_t;
  exp_t exp_q[$];

  task automatic check(input string req, input int got, input int want);
    total_checks++;
    if (got != want) begin
      bad_checks++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, want, $time);
    end
  endtask

  // Driver side of the scoreboard: queue a window's expected count.
  task automatic push_expect(input int win, input int ones);
    exp_t e;
    e.win = win;
    e.val = (ones >= W) ? W - 1 : ones;
    exp_q.push_back(e);
  endtask

  // Monitor side: pop and compare when the strobe appears.
  task automatic pop_compare();
    exp_t e;
    if (exp_q.size() == 0) begin
      check("R3 strobe without window", 1, 0);
      return;
    end
    e = exp_q.pop_front();
    check("R4 window count", int'(result), e.val);
    case (e.win)
      0:    check("R5 all-zero window", int'(result), 0);
      1, 9: check("R5 all-one window clips", int'(result), W - 1);
      2:    check("R6 alternating window", int'(result), W / 2);
      3:    check("R6 every fourth bit", int'(result), W / 4);
      4:    check("R6 three of eight", int'(result), 3 * W / 8);
      default: ;
    endcase
  endtask

  function automatic int vin_of(input int w);
    case (w)
      6: return 256;
      7: return 768;
      8: return 1000;
      default: return 0;
    endcase
  endfunction

  initial begin
    int n = 0;
    int ones = 0;
    int integ = 0;
    int last_res = 0;
    bit pending = 0;
    bit h1 = 0, h2 = 0, h3 = 0;
    logic [15:0] lfsr = 16'hACE1;

    repeat (4) @(negedge clk);
    // R1: quiet outputs under reset
    check("R1 fb_out in reset", int'(fb_out), 0);
    check("R1 result_valid in reset", int'(result_valid), 0);
    check("R1 result in reset", int'(result), 0);
    rst_n = 1'b1;

    for (int j = 0; j < NWIN * W + 2; j++) begin
      int wd, s, wr, vin;
      bit nxt;
      // R3 / R7 / R4: strobe timing and result
      if (pending) begin
        check("R3 strobe due", int'(result_valid), 1);
        if (result_valid) pop_compare();
        last_res = int'(result);
      end else begin
        check("R3 no stray strobe", int'(result_valid), 0);
        check("R7 result holds", int'(result), last_res);
      end
      // R2: three-edge latency from comparator to stream bit
      check("R2 stream latency", int'(fb_out), int'(h3));

      ones += int'(fb_out);
      n++;
      pending = 0;
      if (n % W == 0) begin
        int wfin = n / W - 1;
        push_expect(wfin, ones);
        if (vin_of(wfin) != 0) begin
          int ideal = vin_of(wfin) * W / FULL;
          int err = ones - ideal;
          if (err < 0) err = -err;
          // R8: density tracks the input
          check("R8 closed-loop density", (err <= 12) ? 1 : 0, 1);
          if (err > 12) $display("  R8 detail: count %0d ideal %0d", ones, ideal);
        end
        ones = 0;
        pending = 1;
      end

      s  = j + 3;
      wd = s / W;
      wr = j / W;
      vin = (vin_of(wr) != 0) ? vin_of(wr) : vin_of(wd);
      if (j == 6 * W - 3) integ = 0;
      integ += vin - (fb_out ? FULL : 0);

      case (wd)
        0: nxt = 1'b0;
        1: nxt = 1'b1;
        2: nxt = s[0];
        3: nxt = (s % 4 == 0);
        4: nxt = (s % 8 < 3);
        5: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          nxt = lfsr[0];
        end
        6, 7, 8: nxt = (integ > 0);
        default: nxt = 1'b1;
      endcase

      h3 = h2; h2 = h1; h1 = nxt;
      cmp_in = nxt;
      @(negedge clk);
    end

    check("R3 every window reported", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total_checks++;
      bad_checks++;
      $display("FAIL watchdog: got running expected finished");
      $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
    end
  end

endmodule